// File: doc/BRIEF.md
# NAND Prefetch and Write-Posting Engine

This block sits between a host-side register/stream port and a byte-wide NAND data bus and moves a programmed number of bytes in one direction through a 64-byte FIFO. In read mode it pulls bytes from the flash ahead of host demand and hands them to the host as 32-bit words. In write mode it accepts 16-bit units from the host and drains them byte by byte to the flash. The flash pin timing is reduced to a valid/ready strobe per byte.

Software starts a transfer with a direction, a DMA-mode flag and a byte count. It then watches a status word that holds the FIFO fill level and the bytes still to move, and finishes with an explicit stop. In DMA mode the engine raises one request pulse per 64-byte frame. Each frame is meant to be serviced as sixteen 32-bit beats, or thirty-two 16-bit pushes on the write side. A read length must be a multiple of 4 and a write length a multiple of 2. Software moves any odd residue by itself.

Back-pressure rules: the host read stream keeps `hrd_valid` high and `hrd_data` stable until a word is taken. The host write stream and the flash read stream may drop `valid` at any cycle. A transfer happens only in a cycle where valid and ready are both high at the rising edge.

Top module: `nand_buffer_engine`

## Requirements
- R1: After reset the engine is idle. `busy` is 0, `status` is all zeros, and none of `hrd_valid`, `hwr_ready`, `fl_rd_ready`, `fl_wr_valid`, `dma_req` or `done` is asserted.
- R2: A `start` pulse while idle is taken at the next rising edge. From then on `busy` is 1 and `status[13:0]` equals `start_len`. `start_write` selects the direction: 0 reads from the flash, 1 writes to the flash.
- R3: In read mode, flash bytes are taken in order and delivered as 32-bit words, with the earliest byte in bits [7:0]. `fl_rd_ready` is low whenever the FIFO holds 64 bytes or no bytes remain to fetch.
- R4: In write mode, each accepted 16-bit unit reaches the flash low byte first. `hwr_ready` is high only when at least 2 FIFO bytes are free and at least 2 host bytes of the transfer are still unaccepted.
- R5: While busy, `status[30:24]` is the filled byte count in read mode and the free byte count in write mode. It never exceeds 64, and it reads 0 when idle.
- R6: `status[13:0]` drops by one for each byte exchanged on the flash side. It never increases during a transfer, and it is 0 once the transfer is finished.
- R7: `done` is a single-cycle pulse, issued once per transfer, when the remaining count is 0 and the FIFO is empty. `busy` stays 1 after it until `stop`.
- R8: A `start` while busy is refused. `start_err` pulses in the next cycle and direction, length and status are left unchanged.
- R9: With DMA mode enabled, `dma_req` pulses once per 64-byte frame, `start_len / 64` times in total. In read mode a pulse is issued when the FIFO is full. In write mode it is issued when the FIFO is empty. The next pulse waits until the host has moved 64 bytes. Without DMA mode `dma_req` never pulses.
- R10: `stop` returns the engine to idle at the next edge, flushes the FIFO, and takes priority over a simultaneous `start`. A following transfer sees no stale data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request pulse |
| start_write | input | 1 | Direction of the request: 0 read, 1 write |
| start_dma | input | 1 | Enables per-frame DMA requests |
| start_len | input | 14 | Transfer length in bytes |
| stop | input | 1 | Disables the engine and flushes the FIFO |
| busy | output | 1 | Engine holds an accepted transfer |
| start_err | output | 1 | Pulse: start refused because busy |
| status | output | 32 | [30:24] FIFO bytes available, [13:0] bytes remaining |
| done | output | 1 | Pulse: transfer complete |
| dma_req | output | 1 | Pulse: one 64-byte frame may be serviced |
| hrd_valid | output | 1 | Host read word available |
| hrd_ready | input | 1 | Host takes the read word |
| hrd_data | output | 32 | Host read word, earliest byte in [7:0] |
| hwr_valid | input | 1 | Host write unit offered |
| hwr_ready | output | 1 | Engine accepts the write unit |
| hwr_data | input | 16 | Host write unit, first byte in [7:0] |
| fl_rd_valid | input | 1 | Flash presents a read byte |
| fl_rd_ready | output | 1 | Engine takes the flash byte |
| fl_rd_data | input | 8 | Flash read byte |
| fl_wr_valid | output | 1 | Engine presents a byte for the flash |
| fl_wr_ready | input | 1 | Flash accepts the byte |
| fl_wr_data | output | 8 | Byte to the flash |

## Verification
The checker watches, on every cycle, the local rules. These are: a quiet interface when idle, the 64-byte ceiling of the fill field, the remaining count only ever holding or dropping by one, single-cycle `done` and `dma_req` pulses, a refused start that leaves the engine busy, and the full-stop effect of `stop`. Byte order, end-to-end data integrity, the exact number of DMA frames, a single completion per transfer and the absence of stale data after a flush depend on whole transfers. Only the bench's scenarios can show those, under varied stall patterns on both sides.

// File: rtl/nbe_pkg.sv
package nbe_pkg;
  typedef enum logic {
    XFER_RD = 1'b0,
    XFER_WR = 1'b1
  } xfer_dir_e;

  localparam int HOST_RD_BYTES = 4;
  localparam int HOST_WR_BYTES = 2;
endpackage

// File: rtl/nbe_fifo.sv
module nbe_fifo #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [1:0]       push_cnt,
  input  logic [15:0]      push_data,
  input  logic [2:0]       pop_cnt,
  output logic [31:0]      pop_data,
  output logic [CNT_W-1:0] count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (i < int'(push_cnt)) mem[wr_ptr_q + AW'(i)] <= push_data[8*i +: 8];
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_head
    assign pop_data[8*g +: 8] = mem[rd_ptr_q + AW'(g)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + AW'(push_cnt);
      rd_ptr_q <= rd_ptr_q + AW'(pop_cnt);
      cnt_q    <= cnt_q + CNT_W'(push_cnt) - CNT_W'(pop_cnt);
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/nbe_dma.sv
module nbe_dma #(
  parameter int DEPTH = 64,
  parameter int LEN_W = 14,
  localparam int AW = $clog2(DEPTH),
  localparam int CNT_W = AW + 1,
  localparam int FRM_W = LEN_W - AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [FRM_W-1:0] frames,
  input  logic             enable,
  input  logic             rd_mode,
  input  logic [CNT_W-1:0] fifo_cnt,
  input  logic [2:0]       host_step,
  output logic             dma_req
);
  logic [FRM_W-1:0] frames_left_q;
  logic             pend_q;
  logic [CNT_W:0]   moved_q;
  logic [CNT_W:0]   moved_nxt;
  logic             req_q;
  logic             at_edge;
  logic             fire;

  assign at_edge   = rd_mode ? (fifo_cnt == CNT_W'(DEPTH)) : (fifo_cnt == '0);
  assign fire      = enable && !pend_q && (frames_left_q != '0) && at_edge;
  assign moved_nxt = moved_q + (CNT_W+1)'(host_step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frames_left_q <= '0;
      pend_q        <= 1'b0;
      moved_q       <= '0;
      req_q         <= 1'b0;
    end else if (clear) begin
      frames_left_q <= '0;
      pend_q        <= 1'b0;
      moved_q       <= '0;
      req_q         <= 1'b0;
    end else begin
      req_q <= fire;
      if (load) begin
        frames_left_q <= frames;
        pend_q        <= 1'b0;
        moved_q       <= '0;
      end else if (fire) begin
        frames_left_q <= frames_left_q - 1'b1;
        pend_q        <= 1'b1;
        moved_q       <= '0;
      end else if (pend_q) begin
        if (moved_nxt >= (CNT_W+1)'(DEPTH)) begin
          pend_q  <= 1'b0;
          moved_q <= '0;
        end else begin
          moved_q <= moved_nxt;
        end
      end
    end
  end

  assign dma_req = req_q;
endmodule

// File: rtl/nand_buffer_engine.sv
module nand_buffer_engine #(
  parameter int DEPTH = 64,
  parameter int LEN_W = 14,
  localparam int AW = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_write,
  input  logic        start_dma,
  input  logic [13:0] start_len,
  input  logic        stop,
  output logic        busy,
  output logic        start_err,
  output logic [31:0] status,
  output logic        done,
  output logic        dma_req,
  output logic        hrd_valid,
  input  logic        hrd_ready,
  output logic [31:0] hrd_data,
  input  logic        hwr_valid,
  output logic        hwr_ready,
  input  logic [15:0] hwr_data,
  input  logic        fl_rd_valid,
  output logic        fl_rd_ready,
  input  logic [7:0]  fl_rd_data,
  output logic        fl_wr_valid,
  input  logic        fl_wr_ready,
  output logic [7:0]  fl_wr_data
);
  import nbe_pkg::*;

  logic             busy_q, dma_q, done_seen_q, done_q, err_q;
  xfer_dir_e        dir_q;
  logic [LEN_W-1:0] left_q, host_left_q;
  logic [CNT_W-1:0] fifo_cnt, free_cnt;
  logic [31:0]      head;
  logic             accept, is_rd, finished;
  logic             fl_rd_fire, fl_wr_fire, hrd_fire, hwr_fire;
  logic [1:0]       push_cnt;
  logic [2:0]       pop_cnt, host_step;
  logic [15:0]      push_data;

  assign accept   = start && !busy_q && !stop;
  assign is_rd    = (dir_q == XFER_RD);
  assign free_cnt = CNT_W'(DEPTH) - fifo_cnt;

  assign fl_rd_ready = busy_q && is_rd && (fifo_cnt < CNT_W'(DEPTH)) && (left_q != '0);
  assign fl_wr_valid = busy_q && !is_rd && (fifo_cnt != '0);
  assign hrd_valid   = busy_q && is_rd && (fifo_cnt >= CNT_W'(HOST_RD_BYTES));
  assign hwr_ready   = busy_q && !is_rd && (free_cnt >= CNT_W'(HOST_WR_BYTES))
                       && (host_left_q >= LEN_W'(HOST_WR_BYTES));

  assign fl_rd_fire = fl_rd_valid && fl_rd_ready;
  assign fl_wr_fire = fl_wr_valid && fl_wr_ready;
  assign hrd_fire   = hrd_valid && hrd_ready;
  assign hwr_fire   = hwr_valid && hwr_ready;

  assign push_cnt  = is_rd ? {1'b0, fl_rd_fire} : (hwr_fire ? 2'd2 : 2'd0);
  assign pop_cnt   = is_rd ? (hrd_fire ? 3'd4 : 3'd0) : {2'b00, fl_wr_fire};
  assign host_step = hrd_fire ? 3'(HOST_RD_BYTES) : (hwr_fire ? 3'(HOST_WR_BYTES) : 3'd0);
  assign push_data = is_rd ? {8'h00, fl_rd_data} : hwr_data;
  assign finished  = busy_q && (left_q == '0) && (fifo_cnt == '0) && (host_left_q == '0);

  nbe_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(stop || accept),
    .push_cnt(push_cnt), .push_data(push_data),
    .pop_cnt(pop_cnt), .pop_data(head), .count(fifo_cnt)
  );

  nbe_dma #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_dma (
    .clk(clk), .rst_n(rst_n), .clear(stop), .load(accept),
    .frames(start_len[LEN_W-1:AW]), .enable(busy_q && dma_q),
    .rd_mode(is_rd), .fifo_cnt(fifo_cnt), .host_step(host_step),
    .dma_req(dma_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      dir_q       <= XFER_RD;
      dma_q       <= 1'b0;
      left_q      <= '0;
      host_left_q <= '0;
      done_seen_q <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      err_q  <= start && busy_q;
      done_q <= 1'b0;
      if (stop) begin
        busy_q      <= 1'b0;
        left_q      <= '0;
        host_left_q <= '0;
        done_seen_q <= 1'b0;
      end else if (accept) begin
        busy_q      <= 1'b1;
        dir_q       <= xfer_dir_e'(start_write);
        dma_q       <= start_dma;
        left_q      <= start_len;
        host_left_q <= start_len;
        done_seen_q <= 1'b0;
      end else if (busy_q) begin
        left_q      <= left_q - LEN_W'(fl_rd_fire || fl_wr_fire);
        host_left_q <= host_left_q - LEN_W'(host_step);
        if (finished && !done_seen_q) begin
          done_q      <= 1'b1;
          done_seen_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    status = '0;
    status[LEN_W-1:0] = left_q;
    if (busy_q) status[24 +: CNT_W] = is_rd ? fifo_cnt : free_cnt;
  end

  assign busy       = busy_q;
  assign start_err  = err_q;
  assign done       = done_q;
  assign hrd_data   = head;
  assign fl_wr_data = head[7:0];
endmodule

// File: rtl/nbe_checker.sv
module nbe_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        stop,
  input logic        busy,
  input logic        start_err,
  input logic [31:0] status,
  input logic        done,
  input logic        dma_req,
  input logic        hrd_valid,
  input logic        hwr_ready,
  input logic        fl_rd_ready,
  input logic        fl_wr_valid
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(hrd_valid || hwr_ready || fl_rd_ready || fl_wr_valid || dma_req));

  assert_fetch_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd_ready |-> (status[13:0] != 14'd0 && status[30:24] < 7'd64));

  assert_avail_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status[30:24] <= 7'd64);

  assert_left_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stop) |=> (status[13:0] == $past(status[13:0]) ||
                         status[13:0] == 14'($past(status[13:0]) - 14'd1)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_refuse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !stop) |=> (busy && start_err));

  assert_dma_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req);

  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!busy && status == 32'd0));
endmodule

bind nand_buffer_engine nbe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .busy(busy),
  .start_err(start_err), .status(status), .done(done), .dma_req(dma_req),
  .hrd_valid(hrd_valid), .hwr_ready(hwr_ready), .fl_rd_ready(fl_rd_ready),
  .fl_wr_valid(fl_wr_valid)
);

// File: tb/tb_nand_buffer_engine.sv
`timescale 1ns/100ps
module tb_nand_buffer_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, start_write = 0, start_dma = 0, stop = 0;
  logic [13:0] start_len = '0;
  logic busy, start_err, done, dma_req;
  logic [31:0] status;
  logic hrd_valid, hrd_ready = 0, hwr_valid = 0, hwr_ready;
  logic [31:0] hrd_data;
  logic [15:0] hwr_data = '0;
  logic fl_rd_valid = 0, fl_rd_ready, fl_wr_valid, fl_wr_ready = 0;
  logic [7:0] fl_rd_data = '0, fl_wr_data;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  nand_buffer_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_write(start_write),
    .start_dma(start_dma), .start_len(start_len), .stop(stop), .busy(busy),
    .start_err(start_err), .status(status), .done(done), .dma_req(dma_req),
    .hrd_valid(hrd_valid), .hrd_ready(hrd_ready), .hrd_data(hrd_data),
    .hwr_valid(hwr_valid), .hwr_ready(hwr_ready), .hwr_data(hwr_data),
    .fl_rd_valid(fl_rd_valid), .fl_rd_ready(fl_rd_ready), .fl_rd_data(fl_rd_data),
    .fl_wr_valid(fl_wr_valid), .fl_wr_ready(fl_wr_ready), .fl_wr_data(fl_wr_data)
  );

  // {write, dma, length[13:0], seed[7:0]}
  localparam logic [23:0] VECS [7] = '{
    {1'b0, 1'b0, 14'd16,  8'h10}, {1'b0, 1'b0, 14'd128, 8'h37},
    {1'b1, 1'b0, 14'd10,  8'h5A}, {1'b1, 1'b0, 14'd100, 8'hC3},
    {1'b0, 1'b1, 14'd192, 8'h81}, {1'b1, 1'b1, 14'd128, 8'h22},
    {1'b0, 1'b0, 14'd0,   8'h00}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic idle_inputs();
    start = 0; stop = 0; hrd_ready = 0; hwr_valid = 0; fl_rd_valid = 0; fl_wr_ready = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); idle_inputs(); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  task automatic do_start(input bit wr, input bit dm, input int len);
    @(negedge clk); start = 1; start_write = wr; start_dma = dm; start_len = 14'(len);
    @(negedge clk); start = 0;
  endtask

  task automatic run_xfer(input bit wr, input bit dm, input int len, input logic [7:0] seed);
    int fb = 0, hb = 0, owed = 0, nreq = 0, ndone = 0, bad = 0, cyc = 0;
    logic [31:0] exp_w;
    do_start(wr, dm, len);
    chk(busy && status[13:0] == 14'(len), "R2 start loads length", status, len);
    while (ndone == 0 && cyc < 6000) begin
      cyc++;
      if (!wr) begin
        fl_rd_valid = (cyc % 3 != 0);
        fl_rd_data  = 8'(seed + fb);
        hrd_ready   = dm ? (owed > 0) : (cyc % 4 != 1);
      end else begin
        hwr_data    = {8'(seed + hb + 1), 8'(seed + hb)};
        hwr_valid   = dm ? (owed > 0) : (cyc % 3 != 2);
        fl_wr_ready = (cyc % 2 == 0);
      end
      #1;
      if (fl_rd_valid && fl_rd_ready) fb++;
      if (hrd_valid && hrd_ready) begin
        exp_w = {8'(seed + hb + 3), 8'(seed + hb + 2), 8'(seed + hb + 1), 8'(seed + hb)};
        if (hrd_data !== exp_w) bad++;
        hb += 4; owed--;
      end
      if (hwr_valid && hwr_ready) begin hb += 2; owed--; end
      if (fl_wr_valid && fl_wr_ready) begin
        if (fl_wr_data !== 8'(seed + fb)) bad++;
        fb++;
      end
      if (dma_req) begin nreq++; owed += wr ? 32 : 16; end
      if (done) ndone++;
      @(negedge clk);
    end
    idle_inputs();
    chk(ndone == 1, "R7 done pulse seen", ndone, 1);
    if (wr) chk(bad == 0 && fb == len && hb == len, "R4 write data order", bad, 0);
    else    chk(bad == 0 && fb == len && hb == len, "R3 read data order", bad, 0);
    chk(nreq == (dm ? len / 64 : 0), "R9 dma frame count", nreq, dm ? len / 64 : 0);
    chk(busy && status[13:0] == 14'd0, "R6 remaining zero at end", status, 0);
    repeat (3) begin
      #1; if (done) ndone++;
      @(negedge clk);
    end
    chk(ndone == 1 && busy, "R7 single done, busy held", ndone, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R7 watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    int fired;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && status == 32'd0, "R1 reset idle", status, 0);
    chk(!(hrd_valid || hwr_ready || fl_rd_ready || fl_wr_valid || dma_req || done),
        "R1 reset quiet", 1, 0);

    for (int v = 0; v < 7; v++) begin
      run_xfer(VECS[v][23], VECS[v][22], int'(VECS[v][21:8]), VECS[v][7:0]);
      do_stop();
    end

    // R8: refused start after completion, before stop
    run_xfer(1'b0, 1'b0, 16, 8'h44);
    @(negedge clk); start = 1; start_write = 1; start_len = 14'd40;
    @(negedge clk); start = 0;
    chk(start_err == 1'b1, "R8 start_err pulse", start_err, 1);
    chk(busy && status == 32'd0, "R8 state unchanged", status, 0);
    @(negedge clk);
    chk(start_err == 1'b0, "R8 start_err one cycle", start_err, 0);
    do_stop();
    chk(!busy && status == 32'd0, "R10 stop to idle", status, 0);

    // R3/R5: read fetch halts at a full FIFO
    do_start(1'b0, 1'b0, 128);
    fl_rd_valid = 1; fl_rd_data = 8'hEE;
    repeat (80) @(negedge clk);
    chk(status[30:24] == 7'd64, "R5 read fill level", status[30:24], 64);
    chk(!fl_rd_ready, "R3 fetch halted when full", fl_rd_ready, 0);
    chk(status[13:0] == 14'd64, "R6 remaining after 64 fetched", status[13:0], 64);
    do_stop();

    // R10: flushed FIFO gives fresh data
    do_start(1'b0, 1'b0, 4);
    fired = 0;
    repeat (8) begin
      fl_rd_valid = 1; fl_rd_data = 8'(8'hA0 + fired);
      #1; if (fl_rd_ready) fired++;
      @(negedge clk);
    end
    fl_rd_valid = 0;
    chk(hrd_valid && hrd_data == 32'hA3A2A1A0, "R10 no stale data", hrd_data, 32'hA3A2A1A0);
    do_stop();

    // R4/R5: write side stalls, free space runs out
    do_start(1'b1, 1'b0, 100);
    hwr_valid = 1; hwr_data = 16'h1234;
    repeat (40) @(negedge clk);
    chk(status[30:24] == 7'd0, "R5 write free level", status[30:24], 0);
    chk(!hwr_ready, "R4 ready low when full", hwr_ready, 0);
    chk(status[13:0] == 14'd100, "R6 nothing drained", status[13:0], 100);
    do_stop();

    // R10: stop wins over start
    @(negedge clk); start = 1; stop = 1; start_len = 14'd8;
    @(negedge clk); start = 0; stop = 0;
    chk(!busy && status == 32'd0, "R10 stop over start", busy, 0);

    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule